// File: doc/BRIEF.md
# DS3 Receive Status and Interrupt Block

This block sits behind a DS3 receive framer and turns per-frame information into software-visible state. For each received M-frame the framer pulses a strobe and presents the extracted AIC bit and the three FEBE bits. It also drives level flags for loss of signal, alarm indication, idle, far-end receive failure and out-of-frame, plus single-cycle pulses when a P-bit or CP-bit check fails.

A hysteresis qualifier decides whether the stream carries C-bit parity format. It declares the format after a long unbroken run of frames with AIC set. It withdraws the declaration when a short sliding window of recent frames holds enough AIC-zero frames. The qualifier does not move while the framer reports out-of-frame.

Every condition change and every error pulse is latched into an interrupt status register that clears when read. A single `irq` output is raised whenever a latched event has its enable bit set. Software reaches three byte-wide registers over a simple read/write strobe bus.

Top module: `ds3_rx_stat_irq`

## Requirements
- R1: After reset the status register (0x11), the enable register (0x12) and the interrupt status register (0x13) all read 0x00, and `irq` is 0.
- R2: Status bit 3 (AIC) becomes 1 on the 63rd consecutive strobed frame with `aic_bit`=1, and is still 0 after the 62nd.
- R3: While AIC status is 1, it returns to 0 on a strobed frame that leaves 2 or more AIC-zero frames among the last 15 strobed frames. A single AIC-zero frame with no other zero within 15 frames leaves it at 1.
- R4: Frame strobes that arrive while `oof` is 1 neither advance the run count nor update the 15-frame window, and they cannot change AIC status.
- R5: Status bits 2:0 hold the `febe_bits` value of the most recent strobed frame (for example 3'b111 = far end error-free, 3'b011 = far end saw errors). A change of `febe_bits` with no strobe leaves them unchanged.
- R6: Status register at 0x11 is {3'b000, ferf, aic, febe[2:0]}, with bit 4 following `ferf_in`. Writes to 0x11 have no effect.
- R7: The enable register at 0x12 is read/write. Its bit 7 enables the CP-bit source, bit 6 LOS, bit 5 AIS, bit 4 Idle, bit 3 FERF, bit 2 AIC, bit 1 OOF and bit 0 the P-bit source.
- R8: Each change of `los_in`, `ais_in`, `idle_in`, `ferf_in` or `oof_in`, rising or falling, sets the 0x13 bit at the same position as its enable bit (6, 5, 4, 3, 1).
- R9: Any change of AIC status sets 0x13 bit 2. Each `pbit_err` pulse sets bit 0, and each `cpbit_err` pulse sets bit 7.
- R10: A read strobe at 0x13 returns the latched bits and clears them. An event in the same cycle as the read stays latched.
- R11: `irq` is 1 exactly when some 0x13 bit and the matching 0x12 bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per received M-frame |
| aic_bit | input | 1 | AIC bit of the frame being strobed |
| febe_bits | input | 3 | FEBE bits of the frame being strobed |
| los_in | input | 1 | Loss-of-signal condition level |
| ais_in | input | 1 | Alarm indication condition level |
| idle_in | input | 1 | Idle condition level |
| ferf_in | input | 1 | Far-end receive failure level |
| oof_in | input | 1 | Out-of-frame level; freezes the AIC qualifier |
| pbit_err | input | 1 | Pulse per P-bit error |
| cpbit_err | input | 1 | Pulse per CP-bit error |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears 0x13 when addressed) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Enabled-event interrupt |

## Verification
The assertions assume that `frame_stb`, `pbit_err` and `cpbit_err` are single-cycle pulses, and that every input is driven to a known value from reset onward. In particular, the condition flags are low at reset release, so no change event is seen in the first cycle. The bench drives every input on the falling edge from known zero levels and raises each pulse for exactly one cycle. It spaces frames at least one idle cycle apart, so the AIC change event has landed before 0x13 is read.

// File: rtl/ds3_rx_stat_pkg.sv
package ds3_rx_stat_pkg;
   localparam int unsigned BUS_AW = 8;
   localparam int unsigned BUS_DW = 8;
   localparam logic [BUS_AW-1:0] ADDR_STATUS = 8'h11;
   localparam logic [BUS_AW-1:0] ADDR_IEN    = 8'h12;
   localparam logic [BUS_AW-1:0] ADDR_IST    = 8'h13;
   // positions shared by the enable and event registers
   localparam int unsigned EV_PBIT = 0;
   localparam int unsigned EV_OOF  = 1;
   localparam int unsigned EV_AIC  = 2;
   localparam int unsigned EV_FERF = 3;
   localparam int unsigned EV_IDLE = 4;
   localparam int unsigned EV_AIS  = 5;
   localparam int unsigned EV_LOS  = 6;
   localparam int unsigned EV_CP   = 7;
   localparam int unsigned EV_N    = 8;
endpackage

// File: rtl/ds3_aic_qual.sv
module ds3_aic_qual #(
   parameter int unsigned SET_CNT = 63,
   parameter int unsigned WIN_LEN = 15,
   parameter int unsigned CLR_THR = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic aic_bit,
   input  logic oof,
   output logic aic_stat
);
   localparam int unsigned CW = $clog2(SET_CNT + 1);
   localparam int unsigned PW = $clog2(WIN_LEN + 1);

   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end
   if (CLR_THR < 1 || CLR_THR > WIN_LEN) begin : g_bad_thr
      $error("CLR_THR must lie in 1..WIN_LEN");
   end
   if (SET_CNT < 1) begin : g_bad_set
      $error("SET_CNT must be at least 1");
   end

   logic [CW-1:0]      cnt_q, cnt_nxt;
   logic [WIN_LEN-1:0] win_q, win_nxt;
   logic               stat_q, stat_nxt;
   logic               adv;

   function automatic logic [PW-1:0] zero_count(input logic [WIN_LEN-1:0] v);
      logic [PW-1:0] s;
      s = '0;
      for (int i = 0; i < int'(WIN_LEN); i++) s = s + PW'(v[i]);
      return s;
   endfunction

   assign adv = frame_stb & ~oof;

   always_comb begin
      cnt_nxt  = cnt_q;
      win_nxt  = win_q;
      stat_nxt = stat_q;
      if (adv) begin
         win_nxt = {win_q[WIN_LEN-2:0], ~aic_bit};
         if (!aic_bit)
            cnt_nxt = '0;
         else if (cnt_q != CW'(SET_CNT))
            cnt_nxt = cnt_q + 1'b1;
         if (zero_count(win_nxt) >= PW'(CLR_THR))
            stat_nxt = 1'b0;
         else if (cnt_nxt == CW'(SET_CNT))
            stat_nxt = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         win_q  <= '0;
         stat_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         win_q  <= win_nxt;
         stat_q <= stat_nxt;
      end
   end

   assign aic_stat = stat_q;

   p_set_after_run_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> cnt_q == CW'(SET_CNT));
   p_clear_by_window_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q) |-> $countones(win_q) >= CLR_THR);
   p_frozen_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb || oof) |=> ($stable(win_q) && $stable(cnt_q) && $stable(stat_q)));
endmodule

// File: rtl/ds3_chg_det.sv
module ds3_chg_det #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] chg
);
   if (N < 1) begin : g_bad_n
      $error("N must be at least 1");
   end

   for (genvar k = 0; k < int'(N); k++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= 1'b0;
         else        q <= lvl[k];
      end
      assign chg[k] = lvl[k] ^ q;
   end
endmodule

// File: rtl/ds3_irq_latch.sv
module ds3_irq_latch #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_i,
   output logic [W-1:0] ist_o
);
   logic [W-1:0] ist_q;

   for (genvar k = 0; k < int'(W); k++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n)      ist_q[k] <= 1'b0;
         else if (evt_i[k]) ist_q[k] <= 1'b1;
         else if (clr_i)  ist_q[k] <= 1'b0;
      end
   end

   assign ist_o = ist_q;

   p_evt_latched_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((ist_q & $past(evt_i)) == $past(evt_i)));
   p_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (($past(ist_q) & ~ist_q) == '0));
endmodule

// File: rtl/ds3_rx_stat_irq.sv
module ds3_rx_stat_irq
   import ds3_rx_stat_pkg::*;
#(
   parameter int unsigned SET_CNT = 63,
   parameter int unsigned WIN_LEN = 15,
   parameter int unsigned CLR_THR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              aic_bit,
   input  logic [2:0]        febe_bits,
   input  logic              los_in,
   input  logic              ais_in,
   input  logic              idle_in,
   input  logic              ferf_in,
   input  logic              oof_in,
   input  logic              pbit_err,
   input  logic              cpbit_err,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned NLVL = 6;

   logic [2:0]      febe_q;
   logic            aic_stat;
   logic [NLVL-1:0] lvl, chg;
   logic [EV_N-1:0] evt, ist, ien_q;
   logic            ist_clr;

   always_ff @(posedge clk) begin
      if (!rst_n)         febe_q <= '0;
      else if (frame_stb) febe_q <= febe_bits;
   end

   ds3_aic_qual #(.SET_CNT(SET_CNT), .WIN_LEN(WIN_LEN), .CLR_THR(CLR_THR)) aic_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .aic_bit(aic_bit),
      .oof(oof_in), .aic_stat(aic_stat));

   // level order chosen so that chg lines up with event bits 6..1
   assign lvl = {los_in, ais_in, idle_in, ferf_in, aic_stat, oof_in};

   ds3_chg_det #(.N(NLVL)) chg_i (.clk(clk), .rst_n(rst_n), .lvl(lvl), .chg(chg));

   assign evt = {cpbit_err, chg, pbit_err};
   assign ist_clr = bus_rd && (bus_addr == ADDR_IST);

   ds3_irq_latch #(.W(EV_N)) ist_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(ist_clr), .ist_o(ist));

   always_ff @(posedge clk) begin
      if (!rst_n)                               ien_q <= '0;
      else if (bus_wr && bus_addr == ADDR_IEN)  ien_q <= bus_wdata;
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_STATUS: bus_rdata = {3'b000, ferf_in, aic_stat, febe_q};
         ADDR_IEN:    bus_rdata = ien_q;
         ADDR_IST:    bus_rdata = ist;
         default:     bus_rdata = '0;
      endcase
   end

   assign irq = |(ist & ien_q);

   p_febe_latest_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> febe_q == $past(febe_bits));
   p_febe_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(febe_q));
endmodule

// File: tb/ds3_rx_stat_irq_tb_top.sv
module ds3_rx_stat_irq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 0, aic_bit = 0;
   logic [2:0] febe_bits = 0;
   logic       los_in = 0, ais_in = 0, idle_in = 0, ferf_in = 0, oof_in = 0;
   logic       pbit_err = 0, cpbit_err = 0;
   logic [7:0] bus_addr = 0, bus_wdata = 0;
   logic       bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   ds3_rx_stat_irq dut_i (.*);

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic frame(input logic a, input logic [2:0] f);
      @(negedge clk);
      frame_stb = 1'b1; aic_bit = a; febe_bits = f;
      @(posedge clk);
      #1 frame_stb = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic idle_cyc();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h11, d); chk("R1 status", d, 8'h00);
      rd(8'h12, d); chk("R1 enable", d, 8'h00);
      rd(8'h13, d); chk("R1 ist", d, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);

      // R7 enable read/write, R6 status write ignored
      wr(8'h12, 8'hA5); rd(8'h12, d); chk("R7 enable rw", d, 8'hA5);
      wr(8'h12, 8'h5A); rd(8'h12, d); chk("R7 enable rw2", d, 8'h5A);
      wr(8'h12, 8'h00);
      wr(8'h11, 8'hFF); rd(8'h11, d); chk("R6 status write ignored", d, 8'h00);
      rd(8'h13, d);

      // R2 run of ones, checked after every frame
      for (int n = 1; n <= 62; n++) begin
         frame(1'b1, 3'b111);
         rd(8'h11, d); chk("R2 below threshold", d, 8'h07);
      end
      frame(1'b1, 3'b111);
      rd(8'h11, d); chk("R2 set on 63rd", d, 8'h0F);
      rd(8'h13, d); chk("R9 aic event on set", d, 8'h04);
      rd(8'h13, d); chk("R10 cleared by read", d, 8'h00);

      // R5 febe without strobe ignored
      @(negedge clk); febe_bits = 3'b010; idle_cyc();
      rd(8'h11, d); chk("R5 no strobe no change", d, 8'h0F);

      // R3 isolated zero keeps, second zero within window clears
      frame(1'b0, 3'b011);
      rd(8'h11, d); chk("R3 single zero holds / R5 febe 011", d, 8'h0B);
      for (int n = 0; n < 15; n++) frame(1'b1, 3'b111);
      frame(1'b0, 3'b111);
      rd(8'h11, d); chk("R3 zero outside window holds", d, 8'h0F);
      for (int n = 0; n < 5; n++) frame(1'b1, 3'b111);
      rd(8'h13, d);
      frame(1'b0, 3'b111);
      rd(8'h11, d); chk("R3 second zero clears", d, 8'h07);
      rd(8'h13, d); chk("R9 aic event on clear", d, 8'h04);

      // R4 OOF freezes qualifier
      @(negedge clk); oof_in = 1'b1; idle_cyc();
      rd(8'h13, d); chk("R8 oof rise", d, 8'h02);
      for (int n = 0; n < 70; n++) frame(1'b1, 3'b111);
      rd(8'h11, d); chk("R4 frozen under oof", d, 8'h07);
      @(negedge clk); oof_in = 1'b0; idle_cyc();
      rd(8'h13, d); chk("R8 oof fall", d, 8'h02);
      for (int n = 0; n < 62; n++) frame(1'b1, 3'b111);
      rd(8'h11, d); chk("R4 run not advanced by oof frames", d, 8'h07);
      frame(1'b1, 3'b111);
      rd(8'h11, d); chk("R4 set after 63 clean frames", d, 8'h0F);
      @(negedge clk); oof_in = 1'b1; idle_cyc();
      for (int n = 0; n < 3; n++) frame(1'b0, 3'b111);
      rd(8'h11, d); chk("R4 zeros under oof ignored", d, 8'h0F);
      @(negedge clk); oof_in = 1'b0; idle_cyc();
      rd(8'h13, d);

      // R8 condition changes, both directions
      for (int i = 0; i < 4; i++) begin
         logic [7:0] bit_exp;
         bit_exp = 8'h40 >> i;
         @(negedge clk);
         case (i) 0: los_in = 1; 1: ais_in = 1; 2: idle_in = 1; default: ferf_in = 1; endcase
         idle_cyc();
         rd(8'h13, d); chk("R8 rising change", d, bit_exp);
         if (i == 3) begin
            rd(8'h11, d); chk("R6 ferf bit4", d, 8'h1F);
         end
         @(negedge clk);
         case (i) 0: los_in = 0; 1: ais_in = 0; 2: idle_in = 0; default: ferf_in = 0; endcase
         idle_cyc();
         rd(8'h13, d); chk("R8 falling change", d, bit_exp);
      end

      // R9 error pulses
      @(negedge clk); pbit_err = 1; idle_cyc(); pbit_err = 0;
      rd(8'h13, d); chk("R9 pbit", d, 8'h01);
      @(negedge clk); cpbit_err = 1; idle_cyc(); cpbit_err = 0;
      rd(8'h13, d); chk("R9 cpbit", d, 8'h80);

      // R10 event coincident with clearing read survives
      @(negedge clk);
      bus_addr = 8'h13; bus_rd = 1; pbit_err = 1;
      #1 chk("R10 read before clear", bus_rdata, 8'h00);
      @(posedge clk); #1 bus_rd = 0; pbit_err = 0;
      rd(8'h13, d); chk("R10 coincident event kept", d, 8'h01);

      // R11 exhaustive enable sweep against ist = 0x81
      @(negedge clk); pbit_err = 1; cpbit_err = 1; idle_cyc(); pbit_err = 0; cpbit_err = 0;
      for (int e = 0; e < 256; e++) begin
         wr(8'h12, 8'(e));
         chk("R11 irq mask", {7'd0, irq}, {7'd0, |(8'(e) & 8'h81)});
      end
      wr(8'h12, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule